// File: doc/BRIEF.md
# Multi-Format Serial Audio Input Receiver

This block turns a serial stereo audio stream into parallel left and right samples. The stream is two's complement, most significant bit first, and is sampled on each rising edge of the bit clock, which also clocks the whole block. A frame clock toggles once per half-frame. The frame rate is fs. One format input and three shared lines choose between three stream layouts. The shared lines change role with the layout.

In the right-justified layout, left and right words alternate on a single line. The word sits against the frame clock edge that closes its half-frame, and two select lines give its length. In the left-justified alternating layout, a 24-bit word starts on the first bit clock after each frame edge. The left half is the one that begins on a falling frame edge. In the simultaneous layout, left and right arrive together on two lines, left-justified, once per frame.

The block sign-extends every captured word to the output width. After each completed left/right pair it raises a one-cycle valid strobe. Crossing into a system clock and any resynchronisation are left to the surrounding logic.

Top module: `aud_rx`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and left_o and right_o are all zero.
- R2: With fmt_i=0 the serial data is on line0_i, and line1_i/line2_i select the word length: 0/0 gives 24 bits, 1/0 gives 20, 0/1 gives 18 and 1/1 gives 16. The word is the last N bits sampled before the frame edge that ends the half-frame. Earlier bits in that half-frame have no effect.
- R3: A right-justified word of N bits is sign-extended from bit N-1 to the full output width.
- R4: With fmt_i=1 and line0_i=0, words alternate on line1_i. Each word is the first 24 bits sampled from the first bit-clock edge after a frame edge, MSB first. Further bits in that half-frame have no effect, so a half-frame of exactly 24 bits is enough.
- R5: In the layout of R4, the start edge is the falling edge of frame_i, and the low half-frame carries the left word.
- R6: With fmt_i=1 and line0_i=1, the left word is on line1_i and the right word is on line2_i. Both are the first 24 bits after the rising frame edge, and the half-frame after the falling edge is ignored.
- R7: With fmt_i=0 or the layout of R6, the start edge is the rising edge of frame_i, and the high half-frame carries the left word.
- R8: valid_o pulses for exactly one cycle, on the cycle after the bit-clock edge that sees a start edge closing a complete pair. left_o/right_o change only with that pulse and then hold.
- R9: After reset, no pair is output until a full frame that begins on a start edge has been received. Partial half-frames seen before the first start edge are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; data sampled on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 1 | 0: right-justified alternating; 1: left-justified layouts |
| line0_i | input | 1 | fmt_i=0: serial data; fmt_i=1: 0 alternating, 1 simultaneous |
| line1_i | input | 1 | fmt_i=0: length select A; fmt_i=1: left (or alternating) data |
| line2_i | input | 1 | fmt_i=0: length select B; fmt_i=1: right data (simultaneous) |
| frame_i | input | 1 | Frame clock at fs |
| left_o | output | W | Sign-extended left sample |
| right_o | output | W | Sign-extended right sample |
| valid_o | output | 1 | One-cycle strobe per completed pair |

## Verification
The bench fills the bits ahead of each right-justified word with random values. A design that took the word from the wrong end of the half-frame, or that masked with the wrong length, would therefore output noise instead of the expected sign-extended word.

Left-justified words are followed by junk trailing bits. A design that kept shifting past 24 bits would lose the MSBs. A design that used the wrong start polarity would swap left and right. The half-frame is also cut to exactly 24 bits, which catches a capture that is off by one.

A reset released inside a left half-frame checks that a partial word is never presented as a sample. Across every scenario, the number of valid strobes is counted, which exposes any strobe wider than one cycle.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int unsigned MAX_W = 24;
  localparam int unsigned LEN_BITS = 6;

  typedef logic [LEN_BITS-1:0] len_t;

  typedef enum logic [1:0] {
    MODE_RJ     = 2'd0,
    MODE_LJ_ALT = 2'd1,
    MODE_LJ_SIM = 2'd2
  } rx_mode_e;

  function automatic rx_mode_e decode_mode(input logic fmt, input logic sel);
    if (!fmt) return MODE_RJ;
    return sel ? MODE_LJ_SIM : MODE_LJ_ALT;
  endfunction

  function automatic len_t decode_len(input logic sel_a, input logic sel_b);
    case ({sel_b, sel_a})
      2'b00:   return len_t'(24);
      2'b01:   return len_t'(20);
      2'b10:   return len_t'(18);
      default: return len_t'(16);
    endcase
  endfunction
endpackage

// File: rtl/aud_rx_edge.sv
module aud_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic start_lvl_i,
  output logic toggle_o,
  output logic start_o
);
  logic frame_q, primed_q;

  // first cycle after reset only loads the reference level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q  <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      frame_q  <= frame_i;
      primed_q <= 1'b1;
    end
  end

  assign toggle_o = primed_q && (frame_i != frame_q);
  assign start_o  = toggle_o && (frame_i == start_lvl_i);
endmodule

// File: rtl/aud_rx_rj_shift.sv
module aud_rx_rj_shift #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         d_i,
  output logic [W-1:0] sr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_o <= '0;
    else         sr_o <= {sr_o[W-2:0], d_i};
  end
endmodule

// File: rtl/aud_rx_lj_lane.sv
module aud_rx_lj_lane #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         d_i,
  output logic [W-1:0] word_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;

  // counter saturates at W: later bits of the half-frame are dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      cnt_q  <= CW'(W);
    end else if (restart_i) begin
      word_o <= {{(W-1){1'b0}}, d_i};
      cnt_q  <= CW'(1);
    end else if (cnt_q < CW'(W)) begin
      word_o <= {word_o[W-2:0], d_i};
      cnt_q  <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/aud_rx.sv
module aud_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned W = aud_rx_pkg::MAX_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fmt_i,
  input  logic         line0_i,
  input  logic         line1_i,
  input  logic         line2_i,
  input  logic         frame_i,
  output logic [W-1:0] left_o,
  output logic [W-1:0] right_o,
  output logic         valid_o
);
  localparam int unsigned LANES = 2;

  rx_mode_e mode;
  len_t     len;
  logic     start_lvl, toggle, start, is_sim, lj_restart;
  logic [W-1:0] rj_sr, rj_word, half_word, hold_q;
  logic [LANES-1:0][W-1:0] lj_word;
  logic [LANES-1:0] lane_d;
  logic synced_q, have_left_q;

  function automatic logic [W-1:0] sext(input logic [W-1:0] v, input len_t n);
    logic [W-1:0] r;
    for (int i = 0; i < int'(W); i++)
      r[i] = (i < int'(n)) ? v[i] : v[n - len_t'(1)];
    return r;
  endfunction

  assign mode      = decode_mode(fmt_i, line0_i);
  assign len       = decode_len(line1_i, line2_i);
  assign is_sim    = (mode == MODE_LJ_SIM);
  assign start_lvl = (mode != MODE_LJ_ALT);

  aud_rx_edge i_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .start_lvl_i(start_lvl),
    .toggle_o   (toggle),
    .start_o    (start)
  );

  aud_rx_rj_shift #(.W(W)) i_rj (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (line0_i),
    .sr_o  (rj_sr)
  );

  assign lane_d     = {line2_i, line1_i};
  assign lj_restart = is_sim ? start : toggle;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    aud_rx_lj_lane #(.W(W)) i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .restart_i(lj_restart),
      .d_i      (lane_d[g]),
      .word_o   (lj_word[g])
    );
  end

  assign rj_word   = sext(rj_sr, len);
  assign half_word = (mode == MODE_RJ) ? rj_word : lj_word[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      synced_q    <= 1'b0;
      have_left_q <= 1'b0;
      hold_q      <= '0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (start) begin
        synced_q    <= 1'b1;
        have_left_q <= 1'b0;
        if (synced_q && (is_sim || have_left_q)) begin
          left_o  <= is_sim ? lj_word[0] : hold_q;
          right_o <= is_sim ? lj_word[1] : half_word;
          valid_o <= 1'b1;
        end
      end else if (toggle && synced_q && !is_sim) begin
        hold_q      <= half_word;
        have_left_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk #(
  parameter int unsigned W = 24
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         fmt_i,
  input logic         line0_i,
  input logic         line1_i,
  input logic         line2_i,
  input logic         frame_i,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         valid_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      // R1
      reset_quiet_chk: assert (!valid_o && left_o == '0 && right_o == '0);
    end
  end

  // R8
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R8
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));

  // R8
  valid_after_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(frame_i) != $past(frame_i, 2)));

  // R5
  start_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(frame_i) == ($past(fmt_i) ? $past(line0_i) : 1'b1)));

  // R3
  sext16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(fmt_i) && $past(line1_i) && $past(line2_i)) |->
      (left_o[W-1:15] == {(W-15){left_o[15]}} && right_o[W-1:15] == {(W-15){right_o[15]}}));
endmodule

bind aud_rx aud_rx_chk #(.W(W)) i_aud_rx_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .fmt_i  (fmt_i),
  .line0_i(line0_i),
  .line1_i(line1_i),
  .line2_i(line2_i),
  .frame_i(frame_i),
  .left_o (left_o),
  .right_o(right_o),
  .valid_o(valid_o)
);

// File: tb/test_aud_rx.sv
module test_aud_rx;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fmt, line0, line1, line2, frame;
  logic [23:0] left_o, right_o;
  logic valid_o;

  int n_chk = 0, n_fail = 0, cap_n = 0;
  logic [23:0] cap_l[8], cap_r[8];
  bit done = 0;

  always #4 clk = ~clk;

  aud_rx i_aud_rx (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_i(fmt), .line0_i(line0), .line1_i(line1),
    .line2_i(line2), .frame_i(frame), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      if (cap_n < 8) begin
        cap_l[cap_n] = left_o;
        cap_r[cap_n] = right_o;
      end
      cap_n++;
    end
  end

  task automatic check(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] ext(input logic [23:0] w, input int n);
    logic signed [23:0] t;
    t = w << (24 - n);
    return 24'(t >>> (24 - n));
  endfunction

  task automatic reset_dut(input logic f, input logic l0, input logic l1, input logic l2, input logic fr);
    @(negedge clk);
    rst_ni = 1'b0; fmt = f; line0 = l0; line1 = l1; line2 = l2; frame = fr;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    cap_n = 0;
  endtask

  task automatic drive(input logic fr, input logic d0, input logic d1, input logic d2);
    @(negedge clk);
    frame = fr; line0 = d0; line1 = d1; line2 = d2;
  endtask

  task automatic rj_half(input logic lvl, input logic [23:0] w, input int n, input int h);
    for (int i = 0; i < h; i++) begin
      logic b;
      b = (i >= h - n) ? w[h-1-i] : 1'($urandom);
      drive(lvl, b, line1, line2);
    end
  endtask

  task automatic lj_half(input logic lvl, input logic [23:0] wa, input logic [23:0] wb, input int h, input logic sim);
    for (int i = 0; i < h; i++) begin
      logic da, db;
      da = (i < 24) ? wa[23-i] : 1'($urandom);
      db = (sim && i < 24) ? wb[23-i] : 1'($urandom);
      drive(lvl, line0, da, db);
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; fmt = 1'b0; line0 = 1'b1; line1 = 1'b0; line2 = 1'b0; frame = 1'b0;
    repeat (3) begin
      @(negedge clk);
      frame = ~frame; line0 = 1'($urandom);
    end
    check("R1", "valid in reset", 24'(valid_o), 24'd0);
    check("R1", "left in reset", left_o, 24'd0);
    check("R1", "right in reset", right_o, 24'd0);
  endtask

  // right-justified, rising start, high half = left
  task automatic t_rj(input logic a, input logic b, input int n, input int h,
                      input logic [23:0] l0, r0, l1, r1);
    reset_dut(1'b0, 1'b0, a, b, 1'b0);
    rj_half(1'b1, l0, n, h); rj_half(1'b0, r0, n, h);
    rj_half(1'b1, l1, n, h); rj_half(1'b0, r1, n, h);
    rj_half(1'b1, 24'd0, 0, 4);
    check("R8", "rj pair count", 24'(cap_n), 24'd2);
    check("R2", "rj left0", cap_l[0], ext(l0, n));
    check("R3", "rj right0", cap_r[0], ext(r0, n));
    check("R7", "rj left1", cap_l[1], ext(l1, n));
    check("R2", "rj right1", cap_r[1], ext(r1, n));
    rj_half(1'b1, 24'd0, 0, 6);
    check("R8", "rj hold left", left_o, ext(l1, n));
  endtask

  // left-justified alternating, falling start, low half = left
  task automatic t_lj_alt(input int h, input logic [23:0] l0, r0, l1, r1);
    reset_dut(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    lj_half(1'b0, l0, 24'd0, h, 1'b0); lj_half(1'b1, r0, 24'd0, h, 1'b0);
    lj_half(1'b0, l1, 24'd0, h, 1'b0); lj_half(1'b1, r1, 24'd0, h, 1'b0);
    lj_half(1'b0, 24'd0, 24'd0, 4, 1'b0);
    check("R4", "lj pair count", 24'(cap_n), 24'd2);
    check("R5", "lj left0", cap_l[0], l0);
    check("R4", "lj right0", cap_r[0], r0);
    check("R5", "lj left1", cap_l[1], l1);
    check("R4", "lj right1", cap_r[1], r1);
  endtask

  task automatic t_sim(input logic [23:0] l0, r0, l1, r1);
    reset_dut(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    lj_half(1'b1, l0, r0, 32, 1'b1); lj_half(1'b0, ~l0, ~r0, 32, 1'b1);
    lj_half(1'b1, l1, r1, 32, 1'b1); lj_half(1'b0, ~l1, ~r1, 32, 1'b1);
    lj_half(1'b1, 24'd0, 24'd0, 4, 1'b1);
    check("R6", "sim pair count", 24'(cap_n), 24'd2);
    check("R6", "sim left0", cap_l[0], l0);
    check("R6", "sim right0", cap_r[0], r0);
    check("R7", "sim left1", cap_l[1], l1);
    check("R6", "sim right1", cap_r[1], r1);
  endtask

  // reset released inside a left half-frame
  task automatic t_partial;
    reset_dut(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    rj_half(1'b1, 24'hABCDEF, 24, 20);
    rj_half(1'b0, 24'h123456, 24, 32);
    check("R9", "no pair before full frame", 24'(cap_n), 24'd0);
    rj_half(1'b1, 24'h7F0011, 24, 32); rj_half(1'b0, 24'h80FF22, 24, 32);
    rj_half(1'b1, 24'd0, 0, 4);
    check("R9", "pair count", 24'(cap_n), 24'd1);
    check("R9", "left", cap_l[0], 24'h7F0011);
    check("R9", "right", cap_r[0], 24'h80FF22);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rj(1'b0, 1'b0, 24, 32, 24'h812345, 24'h7ABCDE, 24'hFFFFFF, 24'h000001);
    t_rj(1'b1, 1'b0, 20, 32, 24'h0F8001, 24'h07FFFF, 24'h000000, 24'h0ACE12);
    t_rj(1'b0, 1'b1, 18, 24, 24'h020000, 24'h01FFFF, 24'h03FFFF, 24'h015555);
    t_rj(1'b1, 1'b1, 16, 32, 24'h008001, 24'h007FFF, 24'h00FFFF, 24'h001234);
    t_rj(1'b1, 1'b1, 16, 16, 24'h00C3A5, 24'h005A3C, 24'h008000, 24'h000001);
    t_lj_alt(32, 24'h800001, 24'h7FFFFE, 24'hC0FFEE, 24'h135790);
    t_lj_alt(24, 24'hA5A5A5, 24'h5A5A5A, 24'h000000, 24'hFFFFFF);
    t_sim(24'h1357BD, 24'hFEDCBA, 24'h800000, 24'h7FFFFF);
    t_partial();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule